// File: doc/BRIEF.md
# Configurable Register Macrocell Array

This block holds a row of configurable macrocells that sit behind a programmable AND/OR array. Each cell receives two sum-term signals, a data term and an enable term, and turns them into a feedback signal and, for output cells, a pin value. The array itself is outside this block. The default build has ten output cells, which drive a tri-state pad, and eight buried cells, which only return their value to the array.

Each cell has its own configuration and runs in one of three modes. `MC_COMB` passes the data term straight through. `MC_DE` is a flip-flop on the shared clock `clk_com` that uses the enable term as a synchronous clock enable. `MC_SUMCLK` is a flip-flop that is always enabled and whose clock is the enable term itself, so that cell can be clocked without reference to `clk_com`. The mode is fixed by configuration and has no transitions of its own. It changes only when software rewrites the configuration bits, and any cell can move between any two modes that way. Polarity bits invert the data term (output cells only) and the enable term before the cell uses them. A single active-high reset clears every register asynchronously. Because the pad driver inverts, an output cell that has been cleared and is enabled drives a one.

Output cells give two feedback signals. One is taken from the cell before the pad buffer and is always valid. The other is read back from the pad, so when the output enable is low that signal follows whatever drives the pin from outside. Buried cells return both the true and the complemented value of their register.

Top module: `plx_mc_array`

## Requirements
- R1: While `rst_term` is 1, every cell whose registered bit is 1 holds 0 on its feedback, and this holds even when a clock edge arrives with the enable active. When reset is released, the next enabled edge loads normally.
- R2: With the registered bit at 0 (`MC_COMB`), `out_fb_int[i]` equals `out_d[i] ^ out_xd[i]` without waiting for any clock.
- R3: With the registered bit at 1 and the clock-select bit at 1 (`MC_DE`), a rising edge of `clk_com` while `e ^ xe` is 1 loads `d ^ xd`, and the new value appears on the feedback after that edge.
- R4: In `MC_DE`, a rising edge of `clk_com` while `e ^ xe` is 0 leaves the register unchanged, whatever the data term is.
- R5: With the registered bit at 1 and the clock-select bit at 0 (`MC_SUMCLK`), a rising edge of `e ^ xe` loads `d ^ xd`. Edges of `clk_com` have no effect on that cell.
- R6: When `out_oe[i]` is 1, `pad[i]` carries the inverse of `out_fb_int[i]`.
- R7: When `out_oe[i]` is 0, the cell leaves `pad[i]` undriven and `out_fb_pin[i]` follows the level driven from outside. `out_fb_int[i]` is not affected.
- R8: Buried cells have no data-polarity bit. `bur_fb_t` is the cell value, `bur_fb_c` is its complement, and the enable polarity bit `bur_xe` works as it does on output cells.
- R9: Cells are configured independently, so cells in different modes run side by side without disturbing each other.
- R10: In `MC_DE` with `xe` at 1, a low enable term enables the load and a high one holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_com | input | 1 | Shared register clock |
| rst_term | input | 1 | Asynchronous reset of all registers, active high |
| out_d | input | N_OUT | Data sum terms, output cells |
| out_e | input | N_OUT | Enable/clock sum terms, output cells |
| out_oe | input | N_OUT | Output-enable product terms |
| out_cksel | input | N_OUT | 1 = shared clock, 0 = sum-term clock |
| out_regen | input | N_OUT | 1 = registered, 0 = combinational |
| out_xd | input | N_OUT | Data polarity invert |
| out_xe | input | N_OUT | Enable polarity invert |
| pad | inout | N_OUT | Tri-state pins, driven inverted |
| out_fb_int | output | N_OUT | Feedback taken before the pad buffer |
| out_fb_pin | output | N_OUT | Feedback read back from the pad |
| bur_d | input | N_BUR | Data sum terms, buried cells |
| bur_e | input | N_BUR | Enable/clock sum terms, buried cells |
| bur_cksel | input | N_BUR | 1 = shared clock, 0 = sum-term clock |
| bur_regen | input | N_BUR | 1 = registered, 0 = combinational |
| bur_xe | input | N_BUR | Enable polarity invert |
| bur_fb_t | output | N_BUR | Buried cell true feedback |
| bur_fb_c | output | N_BUR | Buried cell complement feedback |

## Verification
Two events can land on the same shared-clock edge: the asynchronous reset and an enabled `MC_DE` load. The bench raises `rst_term` half a cycle ahead of an edge at which the enable is active and the data is 1. The register must read 0 after that edge. After release, the next edge must load the 1. A second overlap is a sum-term clock edge that falls between shared-clock edges while other cells are loading on `clk_com`. Each cell's captured value is then compared against its own trigger.

// File: rtl/plx_mc_pkg.sv
package plx_mc_pkg;

    typedef enum logic [1:0] {
        MC_COMB   = 2'd0,
        MC_SUMCLK = 2'd1,
        MC_DE     = 2'd2
    } mc_mode_e;

    function automatic mc_mode_e mc_decode(input logic regen, input logic cksel);
        if (!regen)
            return MC_COMB;
        else if (cksel)
            return MC_DE;
        else
            return MC_SUMCLK;
    endfunction

endpackage

// File: rtl/plx_mc_core.sv
module plx_mc_core
    import plx_mc_pkg::*;
(
    input  logic clk_com,
    input  logic rst_term,
    input  logic d_term,
    input  logic e_term,
    input  logic cksel,
    input  logic regen,
    input  logic inv_d,
    input  logic inv_e,
    output logic q
);
    mc_mode_e mode;
    logic     d_pol;
    logic     e_pol;
    logic     q_de;
    logic     q_st;

    assign mode  = mc_decode(regen, cksel);
    assign d_pol = d_term ^ inv_d;
    assign e_pol = e_term ^ inv_e;

    // shared clock, enable term as clock enable
    always_ff @(posedge clk_com or posedge rst_term) begin
        if (rst_term)
            q_de <= 1'b0;
        else if (e_pol)
            q_de <= d_pol;
    end

    // private clock taken from the enable term
    always_ff @(posedge e_pol or posedge rst_term) begin
        if (rst_term)
            q_st <= 1'b0;
        else
            q_st <= d_pol;
    end

    always_comb begin
        unique case (mode)
            MC_COMB:   q = d_pol;
            MC_SUMCLK: q = q_st;
            MC_DE:     q = q_de;
            default:   q = d_pol;
        endcase
    end

endmodule

// File: rtl/plx_mc_outcell.sv
module plx_mc_outcell (
    input  logic clk_com,
    input  logic rst_term,
    input  logic d_term,
    input  logic e_term,
    input  logic oe_term,
    input  logic cksel,
    input  logic regen,
    input  logic inv_d,
    input  logic inv_e,
    inout  wire  pad,
    output logic fb_int,
    output logic fb_pin
);
    logic q;

    plx_mc_core core_i (
        .clk_com  (clk_com),
        .rst_term (rst_term),
        .d_term   (d_term),
        .e_term   (e_term),
        .cksel    (cksel),
        .regen    (regen),
        .inv_d    (inv_d),
        .inv_e    (inv_e),
        .q        (q)
    );

    assign fb_int = q;
    assign pad    = oe_term ? ~q : 1'bz;
    assign fb_pin = pad;

endmodule

// File: rtl/plx_mc_burcell.sv
module plx_mc_burcell (
    input  logic clk_com,
    input  logic rst_term,
    input  logic d_term,
    input  logic e_term,
    input  logic cksel,
    input  logic regen,
    input  logic inv_e,
    output logic fb_t,
    output logic fb_c
);
    logic q;

    plx_mc_core core_i (
        .clk_com  (clk_com),
        .rst_term (rst_term),
        .d_term   (d_term),
        .e_term   (e_term),
        .cksel    (cksel),
        .regen    (regen),
        .inv_d    (1'b0),
        .inv_e    (inv_e),
        .q        (q)
    );

    assign fb_t = q;
    assign fb_c = ~q;

endmodule

// File: rtl/plx_mc_array.sv
module plx_mc_array #(
    parameter int N_OUT = 10,
    parameter int N_BUR = 8
) (
    input  logic             clk_com,
    input  logic             rst_term,
    input  logic [N_OUT-1:0] out_d,
    input  logic [N_OUT-1:0] out_e,
    input  logic [N_OUT-1:0] out_oe,
    input  logic [N_OUT-1:0] out_cksel,
    input  logic [N_OUT-1:0] out_regen,
    input  logic [N_OUT-1:0] out_xd,
    input  logic [N_OUT-1:0] out_xe,
    inout  wire  [N_OUT-1:0] pad,
    output logic [N_OUT-1:0] out_fb_int,
    output logic [N_OUT-1:0] out_fb_pin,
    input  logic [N_BUR-1:0] bur_d,
    input  logic [N_BUR-1:0] bur_e,
    input  logic [N_BUR-1:0] bur_cksel,
    input  logic [N_BUR-1:0] bur_regen,
    input  logic [N_BUR-1:0] bur_xe,
    output logic [N_BUR-1:0] bur_fb_t,
    output logic [N_BUR-1:0] bur_fb_c
);

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        plx_mc_outcell cell_i (
            .clk_com  (clk_com),
            .rst_term (rst_term),
            .d_term   (out_d[i]),
            .e_term   (out_e[i]),
            .oe_term  (out_oe[i]),
            .cksel    (out_cksel[i]),
            .regen    (out_regen[i]),
            .inv_d    (out_xd[i]),
            .inv_e    (out_xe[i]),
            .pad      (pad[i]),
            .fb_int   (out_fb_int[i]),
            .fb_pin   (out_fb_pin[i])
        );
    end

    for (genvar j = 0; j < N_BUR; j++) begin : g_bur
        plx_mc_burcell cell_j (
            .clk_com  (clk_com),
            .rst_term (rst_term),
            .d_term   (bur_d[j]),
            .e_term   (bur_e[j]),
            .cksel    (bur_cksel[j]),
            .regen    (bur_regen[j]),
            .inv_e    (bur_xe[j]),
            .fb_t     (bur_fb_t[j]),
            .fb_c     (bur_fb_c[j])
        );
    end

endmodule

// File: rtl/plx_mc_chk.sv
module plx_mc_chk #(
    parameter int N_OUT = 10,
    parameter int N_BUR = 8
) (
    input logic             clk_com,
    input logic             rst_term,
    input logic [N_OUT-1:0] out_d,
    input logic [N_OUT-1:0] out_e,
    input logic [N_OUT-1:0] out_oe,
    input logic [N_OUT-1:0] out_cksel,
    input logic [N_OUT-1:0] out_regen,
    input logic [N_OUT-1:0] out_xd,
    input logic [N_OUT-1:0] out_xe,
    input logic [N_OUT-1:0] out_fb_int,
    input logic [N_OUT-1:0] out_fb_pin,
    input logic [N_BUR-1:0] bur_d,
    input logic [N_BUR-1:0] bur_e,
    input logic [N_BUR-1:0] bur_cksel,
    input logic [N_BUR-1:0] bur_regen,
    input logic [N_BUR-1:0] bur_xe,
    input logic [N_BUR-1:0] bur_fb_t,
    input logic [N_BUR-1:0] bur_fb_c
);

    // R1
    reset_clear_chk: assert property (@(posedge clk_com)
        rst_term |-> ((out_fb_int & out_regen) == '0) && ((~bur_fb_c & bur_regen) == '0));

    // R6
    pad_invert_chk: assert property (@(posedge clk_com) disable iff (rst_term)
        ((out_fb_pin ^ ~out_fb_int) & out_oe) == '0);

    for (genvar i = 0; i < N_OUT; i++) begin : g_oc
        // R3
        de_load_chk: assert property (@(posedge clk_com) disable iff (rst_term)
            (out_regen[i] && out_cksel[i] && (out_e[i] ^ out_xe[i]))
            |=> (!(out_regen[i] && out_cksel[i]) || out_fb_int[i] == $past(out_d[i] ^ out_xd[i])));

        // R4
        de_hold_chk: assert property (@(posedge clk_com) disable iff (rst_term)
            (out_regen[i] && out_cksel[i] && !(out_e[i] ^ out_xe[i]))
            |=> (!(out_regen[i] && out_cksel[i]) || $stable(out_fb_int[i])));
    end

    for (genvar j = 0; j < N_BUR; j++) begin : g_bc
        // R8
        bur_de_load_chk: assert property (@(posedge clk_com) disable iff (rst_term)
            (bur_regen[j] && bur_cksel[j] && (bur_e[j] ^ bur_xe[j]))
            |=> (!(bur_regen[j] && bur_cksel[j]) || bur_fb_t[j] == $past(bur_d[j])));
    end

endmodule

bind plx_mc_array plx_mc_chk #(.N_OUT(N_OUT), .N_BUR(N_BUR)) chk_i (.*);

// File: tb/plx_mc_array_test.sv
module plx_mc_array_test;
    localparam int N_OUT = 10;
    localparam int N_BUR = 8;
    localparam time CLK_PERIOD = 10;

    logic             clk_com = 1'b0;
    logic             rst_term = 1'b1;
    logic [N_OUT-1:0] out_d = '0, out_e = '0, out_oe = '0, out_cksel = '0;
    logic [N_OUT-1:0] out_regen = '0, out_xd = '0, out_xe = '0;
    logic [N_OUT-1:0] drv_en = '0, drv_val = '0;
    wire  [N_OUT-1:0] pad;
    logic [N_OUT-1:0] out_fb_int, out_fb_pin;
    logic [N_BUR-1:0] bur_d = '0, bur_e = '0, bur_cksel = '0, bur_regen = '0, bur_xe = '0;
    logic [N_BUR-1:0] bur_fb_t, bur_fb_c;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk_com = ~clk_com;

    for (genvar i = 0; i < N_OUT; i++) begin : g_drv
        assign pad[i] = drv_en[i] ? drv_val[i] : 1'bz;
    end

    plx_mc_array #(.N_OUT(N_OUT), .N_BUR(N_BUR)) uut (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic edge_then_settle();
        @(posedge clk_com);
        #1;
    endtask

    task automatic t_reset();
        @(negedge clk_com);
        out_regen = '1; out_cksel = '1; out_oe = '1; out_e = '0;
        bur_regen = '1; bur_cksel = '1; bur_e = '0;
        rst_term = 1'b1;
        edge_then_settle();
        check("R1 out cleared", 32'(out_fb_int), 32'h0);
        check("R6 reset pad ones", 32'(pad), 32'h3FF);
        check("R8 bur true cleared", 32'(bur_fb_t), 32'h0);
        check("R8 bur comp ones", 32'(bur_fb_c), 32'hFF);
        @(negedge clk_com);
        rst_term = 1'b0;
    endtask

    task automatic t_comb();
        @(negedge clk_com);
        out_regen = '0; out_oe = '1;
        out_d = 10'h2A5; out_xd = 10'h0F0;
        #1;
        check("R2 comb pattern a", 32'(out_fb_int), 32'(10'h2A5 ^ 10'h0F0));
        check("R6 comb pad", 32'(pad), 32'(~(10'h2A5 ^ 10'h0F0) & 10'h3FF));
        out_d = 10'h13C; out_xd = 10'h3FF;
        #1;
        check("R2 comb pattern b", 32'(out_fb_int), 32'(10'h13C ^ 10'h3FF));
    endtask

    task automatic t_de();
        @(negedge clk_com);
        out_regen = '1; out_cksel = '1; out_xe = '0; out_xd = 10'h00F;
        out_d = 10'h155; out_e = '1;
        edge_then_settle();
        check("R3 de load", 32'(out_fb_int), 32'(10'h155 ^ 10'h00F));
        @(negedge clk_com);
        out_d = 10'h2AA; out_e = '0;
        edge_then_settle();
        check("R4 de hold", 32'(out_fb_int), 32'(10'h155 ^ 10'h00F));
        @(negedge clk_com);
        out_xe = '1; out_e = '1; out_xd = '0;
        edge_then_settle();
        check("R10 xe high e high holds", 32'(out_fb_int), 32'(10'h155 ^ 10'h00F));
        @(negedge clk_com);
        out_e = '0;
        edge_then_settle();
        check("R10 xe high e low loads", 32'(out_fb_int), 32'(10'h2AA));
        @(negedge clk_com);
        out_xe = '0;
    endtask

    task automatic t_sumclk();
        @(negedge clk_com);
        out_cksel = '0; out_regen = '1; out_xe = '0; out_xd = '0; out_e = '0;
        out_d = 10'h0C3;
        #1 out_e = '1;
        #1;
        check("R5 sum clock load", 32'(out_fb_int), 32'h0C3);
        out_d = 10'h33C;
        edge_then_settle();
        @(posedge clk_com);
        #1;
        check("R5 common clock ignored", 32'(out_fb_int), 32'h0C3);
        @(negedge clk_com);
        out_e = '0;
        #1 out_e = '1;
        #1;
        check("R5 second sum edge", 32'(out_fb_int), 32'h33C);
    endtask

    task automatic t_hiz();
        logic [N_OUT-1:0] held;
        @(negedge clk_com);
        held = out_fb_int;
        out_oe = 10'h3F0; drv_en = 10'h00F; drv_val = 10'h005;
        #1;
        check("R7 pin readback", 32'(out_fb_pin & 10'h00F), 32'h005);
        check("R7 internal unaffected", 32'(out_fb_int), 32'(held));
        check("R6 enabled pins", 32'(pad & 10'h3F0), 32'(~held & 10'h3F0));
        drv_val = 10'h00A;
        #1;
        check("R7 pin follows drive", 32'(out_fb_pin & 10'h00F), 32'h00A);
        drv_en = '0; out_oe = '1;
    endtask

    task automatic t_buried();
        @(negedge clk_com);
        bur_regen = '1; bur_cksel = '1; bur_xe = '0; bur_d = 8'hB4; bur_e = '1;
        edge_then_settle();
        check("R8 bur load", 32'(bur_fb_t), 32'hB4);
        check("R8 bur complement", 32'(bur_fb_c), 32'h4B);
        @(negedge clk_com);
        bur_xe = '1; bur_d = 8'h0F;
        edge_then_settle();
        check("R8 bur xe hold", 32'(bur_fb_t), 32'hB4);
        @(negedge clk_com);
        bur_regen = '0;
        #1;
        check("R8 bur comb no d invert", 32'(bur_fb_t), 32'h0F);
        bur_xe = '0;
    endtask

    task automatic t_mixed();
        @(negedge clk_com);
        out_regen = 10'b11_1111_1100; out_cksel = 10'b00_0011_1111;
        out_xd = '0; out_xe = '0; out_e = '0; out_d = 10'h3FF;
        #1 out_e = 10'h3C0;
        #1;
        check("R9 comb cells live, sum cells loaded, de cells waiting",
              32'(out_fb_int & 10'h3C3), 32'h3C3);
        edge_then_settle();
        check("R9 de cells held with enable low", 32'(out_fb_int & 10'h03C), 32'h03C & 32'(10'h33C >> 0) & 32'h03C);
        @(negedge clk_com);
        out_e = 10'h3FF; out_d = 10'h000;
        edge_then_settle();
        check("R9 de loaded, sum held", 32'(out_fb_int), 32'h3C0);
    endtask

    task automatic t_overlap();
        @(negedge clk_com);
        out_regen = '1; out_cksel = '1; out_xd = '0; out_xe = '0;
        out_d = '1; out_e = '1;
        rst_term = 1'b1;
        edge_then_settle();
        check("R1 reset wins over load", 32'(out_fb_int), 32'h0);
        @(negedge clk_com);
        rst_term = 1'b0;
        edge_then_settle();
        check("R1 load after release", 32'(out_fb_int), 32'h3FF);
    endtask

    initial begin
        t_reset();
        t_comb();
        t_de();
        t_sumclk();
        t_hiz();
        t_buried();
        t_mixed();
        t_overlap();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk_com);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule